// File: doc/BRIEF.md
# Multiplexer-Composed Logic Cell Set

This block shows how one 2:1 multiplexer cell can produce every basic logic function that a late netlist fix might need. Spare multiplexers left in a layout can later be rewired into gates or storage by changing only their pin connections. Every function here is an instance of the same generic multiplexer, `mux2_prim`, which computes `y = sel ? d1 : d0`. The functions differ only in how each instance's pins are tied off and fed back.

The combinational cells are an inverter, a two-input AND and a two-input OR, each built from one multiplexer. There is also an exclusive-OR built from two multiplexers, which shows that the cells compose into further functions. The sequential cells are level-sensitive latches. Each latch is one multiplexer whose output loops back into one of its own data pins. A parameter picks whether the latch is transparent while its enable is high or while it is low. A rising-edge flip-flop is built from a transparent-low master latch followed by a transparent-high slave latch, with both latches on the same clock.

Top module: `mux_cell_lib`

## Requirements
- R1: `y_inv` is the logical complement of `a` for both values of `a`.
- R2: `y_and` is 1 exactly when both `a` and `b` are 1.
- R3: `y_or` is 1 when `a` or `b` (or both) is 1, and 0 only when both are 0.
- R4: `y_xor` is 1 exactly when `a` and `b` differ, and it is formed from two multiplexer instances.
- R5: While `en` is 1, `q_lat_hi` follows `d`, including changes to `d` made during that high phase.
- R6: While `en` is 0, `q_lat_hi` holds the value `d` had when `en` last fell, whatever `d` does.
- R7: While `en` is 0, `q_lat_lo` follows `d`. While `en` is 1, it holds the value `d` had when `en` last rose.
- R8: After each rising edge of `clk`, `q_ff` equals the value `d` had at that edge.
- R9: `q_ff` does not change when `d` changes while `clk` is low, nor while `clk` is high; it changes only at rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1 | First operand of the combinational cells |
| b | input | 1 | Second operand of the combinational cells |
| d | input | 1 | Data input shared by both latches and the flip-flop |
| en | input | 1 | Level enable of both latches |
| clk | input | 1 | Clock of the flip-flop |
| y_inv | output | 1 | Complement of a |
| y_and | output | 1 | a AND b |
| y_or | output | 1 | a OR b |
| y_xor | output | 1 | a XOR b |
| q_lat_hi | output | 1 | Latch that is transparent while en is high |
| q_lat_lo | output | 1 | Latch that is transparent while en is low |
| q_ff | output | 1 | Rising-edge flip-flop output |

## Verification
The latches and the flip-flop all share `d`, so a single change of `d` can open one storage path and close another in the same cycle. The bench changes `d` at falling clock edges, while the flip-flop master is open. In that same phase it sets `en` so that exactly one of the two latches is transparent. It then checks that the open latch shows the new value at once, that the closed latch keeps its old value, and that `q_ff` keeps its old value until the next rising edge. After that edge, `q_ff` must equal the `d` that was present at the edge.

// File: rtl/mux_cell_lib.sv
module mux2_prim (
  input  logic sel,
  input  logic d0,
  input  logic d1,
  output logic y
);
  assign y = sel ? d1 : d0;
endmodule

module mux_latch #(
  parameter bit TRANSPARENT_HIGH = 1'b1
) (
  input  logic en,
  input  logic d,
  output logic q
);
  logic fb;
  assign q = fb;

  generate
    if (TRANSPARENT_HIGH) begin : g_hi
      mux2_prim u_mux (.sel(en), .d0(fb), .d1(d), .y(fb));
    end else begin : g_lo
      mux2_prim u_mux (.sel(en), .d0(d), .d1(fb), .y(fb));
    end
  endgenerate
endmodule

module mux_cell_lib (
  input  logic a,
  input  logic b,
  input  logic d,
  input  logic en,
  input  logic clk,
  output logic y_inv,
  output logic y_and,
  output logic y_or,
  output logic y_xor,
  output logic q_lat_hi,
  output logic q_lat_lo,
  output logic q_ff
);
  logic nb;
  logic master;

  mux2_prim u_inv (.sel(a), .d0(1'b1), .d1(1'b0), .y(y_inv));
  mux2_prim u_and (.sel(a), .d0(1'b0), .d1(b),    .y(y_and));
  mux2_prim u_or  (.sel(a), .d0(b),    .d1(1'b1), .y(y_or));

  mux2_prim u_xinv (.sel(b), .d0(1'b1), .d1(1'b0), .y(nb));
  mux2_prim u_xsel (.sel(a), .d0(b),    .d1(nb),   .y(y_xor));

  mux_latch #(.TRANSPARENT_HIGH(1'b1)) u_lat_hi (.en(en), .d(d), .q(q_lat_hi));
  mux_latch #(.TRANSPARENT_HIGH(1'b0)) u_lat_lo (.en(en), .d(d), .q(q_lat_lo));

  mux_latch #(.TRANSPARENT_HIGH(1'b0)) u_ff_m (.en(clk), .d(d),      .q(master));
  mux_latch #(.TRANSPARENT_HIGH(1'b1)) u_ff_s (.en(clk), .d(master), .q(q_ff));

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  always_comb begin
    assert_inv_R1: assert (y_inv == !a);
    assert_and_R2: assert (y_and == (a && b));
    assert_or_R3:  assert (y_or == (a || b));
    assert_xor_R4: assert (y_xor == (a != b));
  end

  assert_lat_hi_follow_R5: assert property (@(posedge clk) disable iff (!armed)
    en |-> (q_lat_hi == d));
  assert_lat_hi_hold_R6: assert property (@(posedge clk) disable iff (!armed)
    (!en && !$past(en)) |-> $stable(q_lat_hi));
  assert_lat_lo_follow_R7: assert property (@(posedge clk) disable iff (!armed)
    !en |-> (q_lat_lo == d));
  assert_ff_capture_R8: assert property (@(posedge clk) disable iff (!armed)
    $past(armed) |-> (q_ff == $past(d)));
endmodule

// File: tb/mux_cell_lib_bench.sv
module mux_cell_lib_bench;
  logic a = 0, b = 0, d = 0, en = 0, clk = 0;
  logic y_inv, y_and, y_or, y_xor, q_lat_hi, q_lat_lo, q_ff;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mux_cell_lib u_mux_cell_lib (
    .a(a), .b(b), .d(d), .en(en), .clk(clk),
    .y_inv(y_inv), .y_and(y_and), .y_or(y_or), .y_xor(y_xor),
    .q_lat_hi(q_lat_hi), .q_lat_lo(q_lat_lo), .q_ff(q_ff)
  );

  // {a, b, inv, and, or, xor}
  localparam logic [5:0] VEC [4] = '{
    6'b00_1000, 6'b01_1011, 6'b10_0011, 6'b11_0110
  };

  // {en, d} applied at successive falling edges
  localparam logic [1:0] SEQ [12] = '{
    2'b11, 2'b10, 2'b00, 2'b01, 2'b11, 2'b01,
    2'b00, 2'b10, 2'b11, 2'b00, 2'b01, 2'b10
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic e_hi, e_lo, e_ff;
    #1;
    foreach (VEC[i]) begin
      a = VEC[i][5]; b = VEC[i][4];
      #1;
      chk("R1 inverter", y_inv, VEC[i][3]);
      chk("R2 and",      y_and, VEC[i][2]);
      chk("R3 or",       y_or,  VEC[i][1]);
      chk("R4 xor",      y_xor, VEC[i][0]);
    end

    @(negedge clk);
    en = 1; d = 0; #0.5; en = 0; #0.5;
    e_hi = 0; e_lo = 0;
    @(posedge clk); #1; e_ff = 0;
    chk("R8 ff after first edge", q_ff, e_ff);

    foreach (SEQ[i]) begin
      @(negedge clk);
      chk("R9 ff held through high phase", q_ff, e_ff);
      en = SEQ[i][1]; d = SEQ[i][0];
      #0.5;
      if (en) e_hi = d; else e_lo = d;
      chk(en ? "R5 latch-hi follows" : "R6 latch-hi holds", q_lat_hi, e_hi);
      chk(en ? "R7 latch-lo holds"   : "R7 latch-lo follows", q_lat_lo, e_lo);
      chk("R9 ff ignores d in low phase", q_ff, e_ff);
      d = ~d; #0.5;
      if (en) e_hi = d; else e_lo = d;
      chk(en ? "R5 latch-hi tracks change" : "R6 latch-hi ignores change", q_lat_hi, e_hi);
      chk(en ? "R7 latch-lo ignores change" : "R7 latch-lo tracks change", q_lat_lo, e_lo);
      chk("R9 ff ignores second change", q_ff, e_ff);
      @(posedge clk); #1;
      e_ff = d;
      chk("R8 ff captures d at rising edge", q_ff, e_ff);
      d = ~d; #0.5;
      chk("R9 ff ignores d in high phase", q_ff, e_ff);
      d = ~d;
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule